// File: doc/BRIEF.md
# Vertical Field Countdown Counter

This block produces vertical field timing for a raster display. It counts half-line ticks, which arrive at twice the horizontal line rate as a one-cycle enable on a master clock running at 32 times the line rate. The count starts at a preset of 20. In free-running (standard) mode it wraps after 525 half-lines. In resync (non-standard) mode it restarts on each accepted vertical sync edge. A separate mode controller chooses between the two modes. That controller uses the coincidence pulse from this block to decide whether the incoming sync agrees with the internal count.

The vertical sync input passes through a two-flop synchroniser and a rising-edge detector. In resync mode, sync edges that arrive within 492 half-lines of the field start are ignored. When no sync arrives, the field ends after a default of 684 half-lines, so the counter pulls in quickly once sync returns. The mode input is sampled only when a field ends. A mode change therefore never cuts a field short.

Each field end reloads the counter and restarts two gates in the same cycle: a ramp-charge gate 192 master clocks long and a vertical blanking gate 608 master clocks long.

Top module: `vertical_field_counter`

## Requirements
- R1: A synchronous reset loads the count with the preset (20), selects resync behaviour and drops both gates. The first field after reset therefore behaves as resync mode even when `std_mode` is high: an edge after 500 half-lines ends it, and with no sync it ends on the 684th half-line tick.
- R2: `std_mode` is sampled only in a `field_end` cycle (1 = free-running, 0 = resync). A change made during a field takes effect from the next field.
- R3: In free-running mode the field ends, with `field_end` high in the same cycle as a half-line tick, on the 525th tick after the previous field end. The count then goes from 544 back to 20. When both field ends fall on ticks this is 8400 master clocks.
- R4: In free-running mode a vertical sync edge never ends a field.
- R5: `coincident` pulses for one cycle when a conditioned sync edge occurs while the count is 544 or 20. This is the last half-line before the wrap or the first after it, in either mode. The conditioned edge appears two clocks after the input is driven high.
- R6: In resync mode an accepted sync edge raises `field_end` in the edge cycle, two clocks after the raw input rises, and the count restarts at 20.
- R7: In resync mode a sync edge seen after fewer than 492 half-lines of the field is ignored, and the field carries on. An edge seen at 492 or more is accepted.
- R8: In resync mode with no accepted sync, the field ends on the 684th half-line tick.
- R9: `ramp_gate` is high for exactly 192 master clocks, starting in the cycle after `field_end`.
- R10: `blank_gate` is high for exactly 608 master clocks, starting in the cycle after `field_end`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 32 times the line rate |
| rst | input | 1 | Synchronous reset, active high |
| hl_tick | input | 1 | One-cycle half-line enable (master clock divided by 16) |
| vsync_in | input | 1 | Integrated vertical sync, asynchronous |
| std_mode | input | 1 | Mode request from the mode controller: 1 free-running, 0 resync |
| field_end | output | 1 | One-cycle strobe in the cycle the counter reloads |
| coincident | output | 1 | Sync edge landed within one half-line of the wrap point |
| ramp_gate | output | 1 | Ramp-charge gate at the start of each field |
| blank_gate | output | 1 | Vertical blanking gate at the start of each field |

## Verification
The hardest state to reach from the ports is a sync edge that lands exactly on the hold-off boundary, or exactly on the two half-lines around the wrap. Edge detection adds two clocks, and after a resync the tick phase no longer lines up with the field start. The bench therefore counts half-line ticks itself from each observed `field_end`. It raises the raw sync one clock after the N-th tick, so the conditioned edge reaches the counter while exactly N half-lines have elapsed. This makes 491 versus 492 and 524 versus 0 exact cases, whatever the phase.

// File: rtl/vfc_pkg.sv
package vfc_pkg;

  typedef enum logic {
    MODE_RESYNC  = 1'b0,
    MODE_FREERUN = 1'b1
  } vfc_mode_e;

  // Half-lines elapsed in the current field for a given counter value.
  function automatic int unsigned halflines_in_field(int unsigned count, int unsigned preset);
    return count - preset;
  endfunction

  // True on the last half-line before the wrap or the first one after it.
  function automatic logic in_wrap_window(int unsigned count, int unsigned preset,
                                          int unsigned wrap);
    return (count == wrap - 1) || (count == preset);
  endfunction

  // Bits needed to hold values 0..top.
  function automatic int unsigned bits_for(int unsigned top);
    return $clog2(top + 1);
  endfunction

endpackage

// File: rtl/vfc_sync_edge.sv
module vfc_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_in,
  output logic rise
);
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else     pipe <= {pipe[STAGES-1:0], raw_in};
  end

  assign rise = pipe[STAGES-1] & ~pipe[STAGES];
endmodule

// File: rtl/vfc_gate_timer.sv
module vfc_gate_timer #(
  parameter int WIDTH = 192
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic gate
);
  localparam int GW = $clog2(WIDTH + 1);

  logic [GW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst)              left <= '0;
    else if (restart)     left <= GW'(WIDTH);
    else if (left != '0)  left <= left - GW'(1);
  end

  assign gate = (left != '0);
endmodule

// File: rtl/vfc_field_ctr.sv
module vfc_field_ctr
  import vfc_pkg::*;
#(
  parameter int PRESET  = 20,
  parameter int WRAP    = 545,
  parameter int HOLDOFF = 492,
  parameter int DEFLT   = 684,
  parameter int CW      = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hl_tick,
  input  logic          sync_edge,
  input  logic          std_req,
  output logic [CW-1:0] count,
  output vfc_mode_e     mode,
  output logic          field_end,
  output logic          coin
);
  int unsigned elapsed;
  logic        free_wrap;
  logic        default_hit;
  logic        sync_take;

  assign elapsed     = halflines_in_field(int'(count), PRESET);
  assign free_wrap   = (mode == MODE_FREERUN) && hl_tick && (int'(count) == WRAP - 1);
  assign default_hit = (mode == MODE_RESYNC) && hl_tick && (elapsed == DEFLT - 1);
  assign sync_take   = (mode == MODE_RESYNC) && sync_edge && (elapsed >= HOLDOFF);
  assign field_end   = free_wrap | default_hit | sync_take;
  assign coin        = sync_edge && in_wrap_window(int'(count), PRESET, WRAP);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= CW'(PRESET);
      mode  <= MODE_RESYNC;
    end else if (field_end) begin
      count <= CW'(PRESET);
      mode  <= std_req ? MODE_FREERUN : MODE_RESYNC;
    end else if (hl_tick) begin
      count <= count + CW'(1);
    end
  end
endmodule

// File: rtl/vertical_field_counter.sv
module vertical_field_counter
  import vfc_pkg::*;
#(
  parameter int PRESET      = 20,
  parameter int STD_WRAP    = 545,
  parameter int HOLDOFF_HL  = 492,
  parameter int DEFAULT_HL  = 684,
  parameter int RAMP_CLKS   = 192,
  parameter int BLANK_CLKS  = 608,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic hl_tick,
  input  logic vsync_in,
  input  logic std_mode,
  output logic field_end,
  output logic coincident,
  output logic ramp_gate,
  output logic blank_gate
);
  localparam int CW = bits_for(PRESET + DEFAULT_HL);

  logic          vsync_edge;
  logic [CW-1:0] fcount;
  vfc_mode_e     cur_mode;

  vfc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .raw_in(vsync_in), .rise(vsync_edge)
  );

  vfc_field_ctr #(
    .PRESET(PRESET), .WRAP(STD_WRAP), .HOLDOFF(HOLDOFF_HL),
    .DEFLT(DEFAULT_HL), .CW(CW)
  ) u_ctr (
    .clk(clk), .rst(rst), .hl_tick(hl_tick), .sync_edge(vsync_edge),
    .std_req(std_mode), .count(fcount), .mode(cur_mode),
    .field_end(field_end), .coin(coincident)
  );

  vfc_gate_timer #(.WIDTH(RAMP_CLKS)) u_ramp (
    .clk(clk), .rst(rst), .restart(field_end), .gate(ramp_gate)
  );

  vfc_gate_timer #(.WIDTH(BLANK_CLKS)) u_blank (
    .clk(clk), .rst(rst), .restart(field_end), .gate(blank_gate)
  );
endmodule

// File: rtl/vfc_checker.sv
module vfc_checker
  import vfc_pkg::*;
#(
  parameter int PRESET  = 20,
  parameter int HOLDOFF = 492,
  parameter int CW      = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          hl_tick,
  input logic          vsync_edge,
  input logic [CW-1:0] count,
  input vfc_mode_e     mode,
  input logic          field_end,
  input logic          ramp_gate,
  input logic          blank_gate
);
  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (int'(count) == PRESET && mode == MODE_RESYNC && !ramp_gate && !blank_gate));

  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(field_end)) |-> $stable(mode));

  // R3
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    field_end |=> (int'(count) == PRESET));

  // R4
  free_ignores_sync_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_FREERUN && vsync_edge && !hl_tick) |-> !field_end);

  // R7
  holdoff_chk: assert property (@(posedge clk) disable iff (rst)
    (field_end && !hl_tick) |-> (mode == MODE_RESYNC && int'(count) - PRESET >= HOLDOFF));

  // R9
  ramp_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ramp_gate) |-> $past(field_end));

  // R10
  blank_covers_ramp_chk: assert property (@(posedge clk) disable iff (rst)
    ramp_gate |-> blank_gate);
endmodule

bind vertical_field_counter vfc_checker #(
  .PRESET(PRESET), .HOLDOFF(HOLDOFF_HL), .CW(CW)
) u_chk (
  .clk(clk), .rst(rst), .hl_tick(hl_tick), .vsync_edge(vsync_edge),
  .count(fcount), .mode(cur_mode), .field_end(field_end),
  .ramp_gate(ramp_gate), .blank_gate(blank_gate)
);

// File: tb/vertical_field_counter_test.sv
module vertical_field_counter_test;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hl_tick = 1'b0;
  logic vsync_in = 1'b0;
  logic std_mode = 1'b1;
  logic field_end, coincident, ramp_gate, blank_gate;

  int errors = 0;
  int checks = 0;
  int gphase = 0;

  always #(PERIOD/2) clk = ~clk;

  vertical_field_counter uut (
    .clk(clk), .rst(rst), .hl_tick(hl_tick), .vsync_in(vsync_in),
    .std_mode(std_mode), .field_end(field_end), .coincident(coincident),
    .ramp_gate(ramp_gate), .blank_gate(blank_gate)
  );

  typedef struct packed {
    int   t_sync;     // -1: no sync; else raise raw one clock after the N-th tick
    logic next_std;   // std_mode driven during this field
    logic sync_end;   // field expected to end on the sync edge
    int   exp_ticks;  // half-line ticks expected when ending on a tick
    logic exp_coin;
    int   exp_clk;    // 0: length in clocks not checked
  } row_t;

  localparam row_t ROWS [10] = '{
    '{-1,  1'b1, 1'b0, 525, 1'b0, 8400},
    '{524, 1'b1, 1'b0, 525, 1'b1, 0},
    '{0,   1'b1, 1'b0, 525, 1'b1, 0},
    '{300, 1'b0, 1'b0, 525, 1'b0, 0},
    '{-1,  1'b0, 1'b0, 684, 1'b0, 10944},
    '{600, 1'b0, 1'b1, 0,   1'b0, 0},
    '{491, 1'b0, 1'b0, 684, 1'b0, 0},
    '{492, 1'b0, 1'b1, 0,   1'b0, 0},
    '{524, 1'b1, 1'b1, 0,   1'b1, 0},
    '{-1,  1'b1, 1'b0, 525, 1'b0, 0}
  };

  function automatic string row_tag(int i);
    case (i)
      0: return "R3";
      1: return "R5";
      2: return "R5";
      3: return "R4/R2";
      4: return "R8/R2";
      5: return "R6";
      6: return "R7";
      7: return "R7/R6";
      8: return "R5/R6";
      default: return "R2/R3";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Runs clock by clock until field_end is seen; counts stay in the bench.
  task automatic run_field(input int t_sync, input logic next_std,
                           output int clocks, output int ticks, output int raise,
                           output bit coin, output int ramp_n, output int blank_n,
                           output bit end_on_tick);
    bit done = 0;
    clocks = 0; ticks = 0; raise = -1; coin = 0; ramp_n = 0; blank_n = 0;
    end_on_tick = 0;
    if (t_sync == 0) raise = 1;
    while (!done) begin
      clocks++;
      @(negedge clk);
      vsync_in = (raise >= 0 && clocks >= raise && clocks < raise + 4);
      hl_tick  = (gphase == 0);
      gphase   = (gphase + 1) % 16;
      if (clocks == 5) std_mode = next_std;
      #(PERIOD/4);
      if (hl_tick) ticks++;
      if (t_sync > 0 && hl_tick && ticks == t_sync) raise = clocks + 1;
      if (coincident) coin = 1;
      if (ramp_gate)  ramp_n++;
      if (blank_gate) blank_n++;
      if (field_end) begin
        done = 1;
        end_on_tick = hl_tick;
      end
      if (clocks > 12000) begin
        done = 1;
        check(0, "R3/R8", "field never ended, clocks", clocks, 12000);
      end
    end
  endtask

  task automatic reset_steps(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      rst = 1'b1; hl_tick = 1'b0; vsync_in = 1'b0;
      gphase = (gphase + 1) % 16;
    end
    #(PERIOD/4);
    check(!ramp_gate && !blank_gate, "R1", "gates during reset", {ramp_gate, blank_gate}, 0);
    check(!field_end && !coincident, "R1", "strobes during reset", {field_end, coincident}, 0);
    rst = 1'b0;
  endtask

  initial begin
    #(PERIOD * 200000);
    check(0, "ALL", "watchdog expired, cycles", 200000, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int clocks, ticks, raise, ramp_n, blank_n;
    bit coin, eot;

    // R1: reset state, then first field is resync even with std_mode high
    std_mode = 1'b1;
    reset_steps(4);
    run_field(-1, 1'b1, clocks, ticks, raise, coin, ramp_n, blank_n, eot);
    check(eot && ticks == 684, "R1", "first field half-lines after reset", ticks, 684);
    check(ramp_n == 0 && blank_n == 0, "R1", "gates idle before first field end",
          ramp_n + blank_n, 0);

    // table walk
    for (int i = 0; i < 10; i++) begin
      run_field(ROWS[i].t_sync, ROWS[i].next_std, clocks, ticks, raise, coin,
                ramp_n, blank_n, eot);
      if (ROWS[i].sync_end)
        check(raise >= 0 && !eot && clocks == raise + 2, row_tag(i),
              "field end clocks after raw sync rise", clocks - raise, 2);
      else
        check(eot && ticks == ROWS[i].exp_ticks, row_tag(i),
              "half-lines in field", ticks, ROWS[i].exp_ticks);
      check(coin == ROWS[i].exp_coin, row_tag(i), "coincident seen", coin, ROWS[i].exp_coin);
      check(ramp_n == 192, "R9", "ramp gate clocks", ramp_n, 192);
      check(blank_n == 608, "R10", "blank gate clocks", blank_n, 608);
      if (ROWS[i].exp_clk > 0)
        check(clocks == ROWS[i].exp_clk, row_tag(i), "master clocks in field",
              clocks, ROWS[i].exp_clk);
    end

    // R1: reset in the middle of a free-running field, gates high
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      hl_tick = (gphase == 0);
      gphase = (gphase + 1) % 16;
    end
    #(PERIOD/4);
    check(ramp_gate && blank_gate, "R9", "gates high early in field", {ramp_gate, blank_gate}, 3);
    std_mode = 1'b1;
    reset_steps(3);
    run_field(500, 1'b1, clocks, ticks, raise, coin, ramp_n, blank_n, eot);
    check(raise >= 0 && !eot && clocks == raise + 2, "R1",
          "sync accepted after reset despite std_mode", clocks - raise, 2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule